// File: doc/BRIEF.md
# Threshold Offset Register Loader

This block keeps the two offsets that drive a FIFO's almost-empty and almost-full flags. The almost-empty offset (n) and the almost-full offset (m) are each split into a low byte and a high part. Software-free programming is done over the FIFO's own 9-bit data input on the write clock. The registers are read back onto a 9-bit output on the read clock. No address is given: a write-side selector and a separate read-side selector each step through the four registers in a fixed rotation. Each selector keeps its position when a load session ends, so the next session carries on where the last one stopped.

One dual-purpose input, `ld_we2`, is sampled while reset is held. If it is low during reset, the block enters programming mode and the pin then acts as an active-low load control. If it is high during reset, the pin becomes a second, active-high write enable and the offsets keep their defaults. The assembled n is delivered to the read domain through two register stages. The assembled m is delivered to the write domain through one register stage.

Each selector is a four-state machine. Its states are `SEL_E_LO` (empty offset, low byte), `SEL_E_HI` (empty offset, high part), `SEL_F_LO` (full offset, low byte) and `SEL_F_HI` (full offset, high part). Each access moves the selector one state along the ring `SEL_E_LO -> SEL_E_HI -> SEL_F_LO -> SEL_F_HI -> SEL_E_LO`. With no access it holds its state. Reset puts it in `SEL_E_LO`. `DEPTH` must be at least 512 and at most 2^17, so that the high part has 1 to 9 bits.

Top module: `ofs_loader`

## Requirements
- R1: `prog_mode` is set to 1 if `ld_we2` is low, and to 0 if `ld_we2` is high, at the write-clock edges while `rst_n` is low. It does not change after `rst_n` is released, whatever `ld_we2` does.
- R2: After reset, both low-byte registers are 8'h07 and both high parts are zero. So `empty_off` and `full_off` both read 7.
- R3: In programming mode, each write-clock edge with `ld_we2`=0 and `we1_n`=0 writes one register, in the order empty-low, empty-high, full-low, full-high. Low bytes take `din[7:0]`. High parts take `din[HI_W-1:0]`. The offsets are assembled as `{high, low}`.
- R4: The write after the full-high register goes to the empty-low register again.
- R5: Raising `ld_we2` between writes keeps the write selector's position.
- R6: In programming mode, each read-clock edge with `ld_we2`=0 and `re1_n`=`re2_n`=0 puts the next register on `dout`, zero-extended to 9 bits, and sets `dout_vld` for that cycle. Reads use their own selector, which starts at empty-low after reset and follows the same rotation.
- R7: `ld_we2`=0 with `we1_n`=1 changes no register and does not move the write selector.
- R8: `fifo_wr` is high exactly when `we1_n`=0 and `ld_we2`=1, in either mode. In two-enable mode, no register is ever written and no readback occurs.
- R9: When a register write and a register read are requested in the same cycle, the write is performed. The read is dropped: `dout_vld` stays low and the read selector does not move.
- R10: After a register write edge, `full_off` changes one write-clock edge later and `empty_off` changes two read-clock edges later.
- R11: While no read takes place, `dout` holds its last value and `dout_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset, seen on both clocks |
| ld_we2 | input | 1 | Load control (active low) or second write enable (active high), chosen at reset |
| we1_n | input | 1 | Write enable 1, active low |
| re1_n | input | 1 | Read enable 1, active low |
| re2_n | input | 1 | Read enable 2, active low |
| din | input | 9 | Data input carrying offset values |
| fifo_wr | output | 1 | Normal FIFO write strobe |
| prog_mode | output | 1 | 1 when programming mode was chosen at reset |
| dout | output | 9 | Register readback data |
| dout_vld | output | 1 | Readback data was updated this cycle |
| empty_off | output | OFF_W | Assembled almost-empty offset n, read domain |
| full_off | output | OFF_W | Assembled almost-full offset m, write domain |

## Verification
Readback data and `dout_vld` are due right after the read edge that performs the read. `full_off` is due one write edge after the write edge, and `empty_off` two read edges after it. The bench samples one nanosecond after each rising edge. Table entries write once and then idle for two edges before comparing both offsets. The latency test also samples the offsets at the intermediate edges to confirm that they have not changed too early. `fifo_wr` is combinational, so it is checked right after the inputs settle, with no edge in between.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
    localparam int DW     = 9;
    localparam int LO_W   = 8;
    localparam logic [LO_W-1:0] LO_DEF = 8'h07;

    typedef enum logic [1:0] {
        SEL_E_LO = 2'd0,
        SEL_E_HI = 2'd1,
        SEL_F_LO = 2'd2,
        SEL_F_HI = 2'd3
    } off_sel_e;
endpackage

// File: rtl/ofs_sel_fsm.sv
module ofs_sel_fsm
    import ofs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    output off_sel_e sel
);
    off_sel_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEL_E_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                SEL_E_LO: state_d = SEL_E_HI;
                SEL_E_HI: state_d = SEL_F_LO;
                SEL_F_LO: state_d = SEL_F_HI;
                SEL_F_HI: state_d = SEL_E_LO;
            endcase
        end
    end

    assign sel = state_q;
endmodule

// File: rtl/ofs_regbank.sv
module ofs_regbank
    import ofs_pkg::*;
#(
    parameter int HI_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  off_sel_e        sel,
    input  logic [DW-1:0]   din,
    output logic [LO_W-1:0] e_lo,
    output logic [HI_W-1:0] e_hi,
    output logic [LO_W-1:0] f_lo,
    output logic [HI_W-1:0] f_hi
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_lo <= LO_DEF;
            e_hi <= '0;
            f_lo <= LO_DEF;
            f_hi <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_E_LO: e_lo <= din[LO_W-1:0];
                SEL_E_HI: e_hi <= din[HI_W-1:0];
                SEL_F_LO: f_lo <= din[LO_W-1:0];
                SEL_F_HI: f_hi <= din[HI_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
    import ofs_pkg::*;
#(
    parameter int HI_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  off_sel_e        sel,
    input  logic [LO_W-1:0] e_lo,
    input  logic [HI_W-1:0] e_hi,
    input  logic [LO_W-1:0] f_lo,
    input  logic [HI_W-1:0] f_hi,
    output logic [DW-1:0]   dout,
    output logic            dout_vld
);
    localparam int LO_PAD = DW - LO_W;
    localparam int HI_PAD = DW - HI_W;

    logic [DW-1:0] pick;

    always_comb begin
        unique case (sel)
            SEL_E_LO: pick = {{LO_PAD{1'b0}}, e_lo};
            SEL_E_HI: pick = {{HI_PAD{1'b0}}, e_hi};
            SEL_F_LO: pick = {{LO_PAD{1'b0}}, f_lo};
            SEL_F_HI: pick = {{HI_PAD{1'b0}}, f_hi};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= rd_en;
            if (rd_en) dout <= pick;
        end
    end
endmodule

// File: rtl/ofs_sync.sv
module ofs_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
    import ofs_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int OFF_W = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             ld_we2,
    input  logic             we1_n,
    input  logic             re1_n,
    input  logic             re2_n,
    input  logic [DW-1:0]    din,
    output logic             fifo_wr,
    output logic             prog_mode,
    output logic [DW-1:0]    dout,
    output logic             dout_vld,
    output logic [OFF_W-1:0] empty_off,
    output logic [OFF_W-1:0] full_off
);
    localparam int HI_W = OFF_W - LO_W;
    localparam logic [OFF_W-1:0] OFF_DEF = OFF_W'(LO_DEF);

    logic            rd_mode;
    logic            reg_wr;
    logic            reg_rd;
    off_sel_e        wsel;
    off_sel_e        rsel;
    logic [LO_W-1:0] e_lo, f_lo;
    logic [HI_W-1:0] e_hi, f_hi;

    // Mode choice: captured while reset is held, frozen afterwards.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) prog_mode <= !ld_we2;
    end

    ofs_sync #(.W(1), .STAGES(1), .RST_VAL(1'b0)) u_mode_sync (
        .clk(rd_clk), .rst_n(rst_n), .d(prog_mode), .q(rd_mode)
    );

    assign fifo_wr = ld_we2 && !we1_n;
    assign reg_wr  = prog_mode && !ld_we2 && !we1_n;
    // A register write in the same cycle wins; the read is dropped.
    assign reg_rd  = rd_mode && !ld_we2 && !re1_n && !re2_n && !reg_wr;

    ofs_sel_fsm u_wsel (.clk(wr_clk), .rst_n(rst_n), .step(reg_wr), .sel(wsel));
    ofs_sel_fsm u_rsel (.clk(rd_clk), .rst_n(rst_n), .step(reg_rd), .sel(rsel));

    ofs_regbank #(.HI_W(HI_W)) u_bank (
        .clk(wr_clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(wsel), .din(din),
        .e_lo(e_lo), .e_hi(e_hi), .f_lo(f_lo), .f_hi(f_hi)
    );

    ofs_readback #(.HI_W(HI_W)) u_rb (
        .clk(rd_clk), .rst_n(rst_n), .rd_en(reg_rd), .sel(rsel),
        .e_lo(e_lo), .e_hi(e_hi), .f_lo(f_lo), .f_hi(f_hi),
        .dout(dout), .dout_vld(dout_vld)
    );

    ofs_sync #(.W(OFF_W), .STAGES(2), .RST_VAL(OFF_DEF)) u_n_sync (
        .clk(rd_clk), .rst_n(rst_n), .d({e_hi, e_lo}), .q(empty_off)
    );

    ofs_sync #(.W(OFF_W), .STAGES(1), .RST_VAL(OFF_DEF)) u_m_sync (
        .clk(wr_clk), .rst_n(rst_n), .d({f_hi, f_lo}), .q(full_off)
    );
endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
    parameter int OFF_W = 10
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             ld_we2,
    input logic             we1_n,
    input logic             prog_mode,
    input logic             dout_vld,
    input logic [8:0]       dout,
    input logic [OFF_W-1:0] full_off
);
    a_r1_mode_frozen: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(prog_mode));

    a_r8_no_prog_in_we2_mode: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ($past(rst_n) && !prog_mode) |-> $stable(full_off));

    a_r8_no_readback_in_we2_mode: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !prog_mode |=> !dout_vld);

    a_r9_write_wins: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (prog_mode && !ld_we2 && !we1_n) |=> !dout_vld);

    a_r11_dout_holds: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ($past(rst_n) && !dout_vld) |-> $stable(dout));
endmodule

bind ofs_loader ofs_loader_chk #(.OFF_W(OFF_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ld_we2(ld_we2),
    .we1_n(we1_n), .prog_mode(prog_mode), .dout_vld(dout_vld),
    .dout(dout), .full_off(full_off)
);

// File: tb/test_ofs_loader.sv
module test_ofs_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_we2 = 1'b0;
    logic       we1_n = 1'b1;
    logic       re1_n = 1'b1;
    logic       re2_n = 1'b1;
    logic [8:0] din = '0;
    logic       fifo_wr, prog_mode, dout_vld;
    logic [8:0] dout;
    logic [9:0] empty_off, full_off;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ofs_loader i_ofs_loader (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .ld_we2(ld_we2),
        .we1_n(we1_n), .re1_n(re1_n), .re2_n(re2_n), .din(din),
        .fifo_wr(fifo_wr), .prog_mode(prog_mode), .dout(dout),
        .dout_vld(dout_vld), .empty_off(empty_off), .full_off(full_off)
    );

    // {din, expected n, expected m}
    localparam logic [28:0] VEC [6] = '{
        {9'h1A5, 10'h0A5, 10'h007},
        {9'h1FE, 10'h2A5, 10'h007},
        {9'h033, 10'h2A5, 10'h033},
        {9'h0FD, 10'h2A5, 10'h133},
        {9'h010, 10'h210, 10'h133},
        {9'h003, 10'h310, 10'h133}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic reg_write(input logic [8:0] v);
        ld_we2 = 1'b0; we1_n = 1'b0; din = v;
        tick();
        ld_we2 = 1'b1; we1_n = 1'b1;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [9:0] rd_exp [5];
        rd_exp = '{10'h010, 10'h003, 10'h044, 10'h001, 10'h010};

        // Reset with the pin low: programming mode, defaults
        repeat (3) tick();
        chk("R1 prog_mode after low-pin reset", prog_mode, 1);
        chk("R2 empty_off default", empty_off, 10'h007);
        chk("R2 full_off default", full_off, 10'h007);
        chk("R2 dout_vld in reset", dout_vld, 0);
        rst_n = 1'b1; ld_we2 = 1'b1;
        tick();
        chk("R1 prog_mode after pin rises", prog_mode, 1);

        // Vector table: one register write, two idle edges, then compare (R3, R4, R5)
        for (int i = 0; i < 6; i++) begin
            reg_write(VEC[i][28:20]);
            tick(); tick();
            chk(i < 4 ? "R3 empty_off" : "R4 empty_off after wrap", empty_off, VEC[i][19:10]);
            chk(i < 4 ? "R3 full_off" : "R4 full_off after wrap", full_off, VEC[i][9:0]);
        end

        // R7: load low with we1 high is a no-op
        ld_we2 = 1'b0; we1_n = 1'b1; din = 9'h1FF;
        repeat (3) tick();
        ld_we2 = 1'b1;
        tick(); tick();
        chk("R7 empty_off unchanged", empty_off, 10'h310);
        chk("R7 full_off unchanged", full_off, 10'h133);
        // R5: the selector resumes at full-low
        reg_write(9'h044);
        tick(); tick();
        chk("R5 full_off after resume", full_off, 10'h144);

        // R8: FIFO write strobe
        ld_we2 = 1'b1; we1_n = 1'b0; #1;
        chk("R8 fifo_wr with pin high", fifo_wr, 1);
        ld_we2 = 1'b0; #1;
        chk("R8 fifo_wr with pin low", fifo_wr, 0);
        we1_n = 1'b1; ld_we2 = 1'b1; #1;

        // R6: readback order and wrap
        ld_we2 = 1'b0; re1_n = 1'b0; re2_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R6 dout_vld", dout_vld, 1);
            chk("R6 dout", dout, rd_exp[i]);
        end
        re1_n = 1'b1; re2_n = 1'b1; ld_we2 = 1'b1;
        tick();
        chk("R11 dout_vld idle", dout_vld, 0);
        chk("R11 dout held", dout, 10'h010);
        tick();
        chk("R11 dout still held", dout, 10'h010);

        // R9: simultaneous write and read
        ld_we2 = 1'b0; we1_n = 1'b0; re1_n = 1'b0; re2_n = 1'b0; din = 9'h0AA;
        tick();
        chk("R9 read dropped", dout_vld, 0);
        we1_n = 1'b1;
        tick();
        chk("R9 read selector not moved vld", dout_vld, 1);
        chk("R9 read selector not moved data", dout, 10'h003);
        re1_n = 1'b1; re2_n = 1'b1; ld_we2 = 1'b1;
        tick(); tick();
        chk("R9 write performed", full_off, 10'h244);

        // R10: latencies
        reg_write(9'h055);
        chk("R10 n at write edge", empty_off, 10'h310);
        tick();
        chk("R10 n one edge later", empty_off, 10'h310);
        tick();
        chk("R10 n two edges later", empty_off, 10'h355);
        reg_write(9'h000);
        tick();
        reg_write(9'h066);
        chk("R10 m at write edge", full_off, 10'h244);
        tick();
        chk("R10 m one edge later", full_off, 10'h266);

        // Reset with the pin high: two-enable mode
        rst_n = 1'b0; ld_we2 = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 prog_mode after high-pin reset", prog_mode, 0);
        chk("R2 empty_off default again", empty_off, 10'h007);
        chk("R2 full_off default again", full_off, 10'h007);
        ld_we2 = 1'b0; we1_n = 1'b0; re1_n = 1'b0; re2_n = 1'b0; din = 9'h1FF;
        #1;
        chk("R8 no fifo_wr with second enable low", fifo_wr, 0);
        repeat (3) tick();
        chk("R8 no readback in two-enable mode", dout_vld, 0);
        we1_n = 1'b1; re1_n = 1'b1; re2_n = 1'b1;
        tick(); tick();
        chk("R8 full_off untouched", full_off, 10'h007);
        chk("R8 empty_off untouched", empty_off, 10'h007);
        chk("R1 prog_mode frozen", prog_mode, 0);

        summary();
    end
endmodule